// File: doc/BRIEF.md
# Scrolling Line Scan and Drive Level Encoder

This block is the refresh side of a dot-matrix LCD controller with 128 rows and 132 columns. It keeps a 7-bit start-line register and a line counter. The counter supplies the row address for the display RAM. On each line latch pulse the counter steps to the next row. At the end of every frame it is reloaded from the start-line register. Software can scroll the picture vertically by changing the start line, and the RAM contents stay as they are.

The block also keeps a scan index, which names the common line being driven. It counts the frame length from a programmable duty and toggles the frame-alternation signal M at each frame boundary. The RAM row fetched at the current address is presented on `row_data_i`. From that row, M and the display mode controls, the block produces a 3-bit drive level code for every segment column and two codes for the common lines: one for the selected common and one for the unselected commons. All level codes are registered.

Top module: `lcd_scan_encoder`

## Requirements
- R1: A start-line write (`start_wr_i` high for one cycle with `start_line_i`) does not change `row_addr_o` at once. The new value is loaded into the row address at the next frame boundary.
- R2: A line latch that arrives when the scan index equals the last line of the frame is a frame boundary. On the next clock, `row_addr_o` takes the start-line value, `com_idx_o` becomes 0 and `m_o` inverts.
- R3: Any other line latch increments `row_addr_o` modulo 128 (127 is followed by 0) and increments `com_idx_o` by one. In cycles without a line latch, the row address, the scan index and M hold their values.
- R4: `duty_m1_i` gives the number of lines per frame minus one. Values below 15 are treated as 15, so one frame lasts max(`duty_m1_i`,15)+1 line latches, from 16 up to 128.
- R5: Level codes are 3 bits: VSS=0, V0=1, V1=2, V2=3, V3=4, V4=5. Column c occupies `seg_lvl_o[3c+2:3c]`. Every level output is registered and reflects its inputs one clock later.
- R6: In normal mode a segment with data 1 gives V0 when M=1 and VSS when M=0. A segment with data 0 gives V2 when M=1 and V3 when M=0.
- R7: With `reverse_i` high, the data bit is inverted before the segment level is chosen. Data 1 then gives V2 or V3, and data 0 gives V0 or VSS.
- R8: With `all_on_i` high, every pixel is treated as data 1 before the reverse inversion is applied.
- R9: With `disp_on_i` low, every segment takes the data-0 normal level (V2 when M=1, V3 when M=0), whatever `reverse_i`, `all_on_i` and the row data are.
- R10: `com_idx_o` equals the scan index. `com_on_lvl_o` is VSS when M=1 and V0 when M=0. `com_off_lvl_o` is V1 when M=1 and V4 when M=0.
- R11: With `pwr_save_i` high, all segment codes and both common codes are VSS (0), and this overrides every other control.
- R12: While `rst` is high, the row address, start line, scan index and M are 0, and all level outputs are VSS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_wr_i | input | 1 | Start-line register write strobe |
| start_line_i | input | 7 | New start-line value |
| duty_m1_i | input | 7 | Lines per frame minus one |
| line_latch_i | input | 1 | Line latch pulse, one cycle per line |
| row_addr_o | output | 7 | RAM row address of the current line |
| row_data_i | input | 132 | RAM row at `row_addr_o` |
| disp_on_i | input | 1 | Display enable |
| reverse_i | input | 1 | Reverse display |
| all_on_i | input | 1 | Force all pixels lit |
| pwr_save_i | input | 1 | Power save |
| m_o | output | 1 | Frame alternation signal |
| com_idx_o | output | 7 | Index of the selected common line |
| com_on_lvl_o | output | 3 | Level code for the selected common |
| com_off_lvl_o | output | 3 | Level code for the unselected commons |
| seg_lvl_o | output | 396 | Level code for each segment column |

## Verification
The checks assume that a start-line write and a line latch never occur in the same cycle. They also assume that `duty_m1_i` changes only between frames, so the scan index never passes the frame end. The stimulus writes the start line only in cycles without a latch pulse and changes the duty only after a frame boundary has been observed on `m_o`. Mode controls and row data are held steady for a full clock before a level check, so each registered code is compared against inputs that were stable at its capturing edge.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int LVL_W = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_VSS = 3'd0,
        LVL_V0  = 3'd1,
        LVL_V1  = 3'd2,
        LVL_V2  = 3'd3,
        LVL_V3  = 3'd4,
        LVL_V4  = 3'd5
    } drv_lvl_e;

    typedef struct packed {
        logic disp_on;
        logic reverse;
        logic all_on;
        logic pwr_save;
    } disp_mode_t;

    // Segment level for an effective (post-mode) pixel bit
    function automatic drv_lvl_e seg_level(input logic lit, input logic m);
        if (lit) return m ? LVL_V0 : LVL_VSS;
        return m ? LVL_V2 : LVL_V3;
    endfunction

    // Common level for a selected or unselected line
    function automatic drv_lvl_e com_level(input logic sel, input logic m);
        if (sel) return m ? LVL_VSS : LVL_V0;
        return m ? LVL_V1 : LVL_V4;
    endfunction

endpackage

// File: rtl/lcd_line_sequencer.sv
module lcd_line_sequencer #(
    parameter int ROWS     = 128,
    parameter int MIN_DUTY = 16,
    localparam int LINE_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr_i,
    input  logic [LINE_W-1:0] start_line_i,
    input  logic [LINE_W-1:0] duty_m1_i,
    input  logic              line_latch_i,
    output logic [LINE_W-1:0] row_addr_o,
    output logic [LINE_W-1:0] scan_idx_o,
    output logic              m_o
);
    localparam logic [LINE_W-1:0] MIN_LAST = LINE_W'(MIN_DUTY - 1);
    localparam logic [LINE_W-1:0] ONE      = LINE_W'(1);

    logic [LINE_W-1:0] start_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] scan_q;
    logic              m_q;
    logic [LINE_W-1:0] last_w;
    logic              wrap_w;

    // Effective last line of the frame, clamped to the minimum duty
    always_comb begin
        last_w = (duty_m1_i < MIN_LAST) ? MIN_LAST : duty_m1_i;
        wrap_w = line_latch_i && (scan_q >= last_w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            line_q  <= '0;
            scan_q  <= '0;
            m_q     <= 1'b0;
        end else begin
            if (start_wr_i) start_q <= start_line_i;
            if (wrap_w) begin
                line_q <= start_q;
                scan_q <= '0;
                m_q    <= ~m_q;
            end else if (line_latch_i) begin
                line_q <= line_q + ONE;
                scan_q <= scan_q + ONE;
            end
        end
    end

    assign row_addr_o = line_q;
    assign scan_idx_o = scan_q;
    assign m_o        = m_q;

    // R2: frame boundary reloads the start line, clears the scan, flips M
    assert_frame_reload_R2: assert property (@(posedge clk) disable iff (rst)
        wrap_w |=> (line_q == $past(start_q)) && (scan_q == '0) && (m_q != $past(m_q)));

    // R3: ordinary latch steps both counters by one, modulo the row count
    assert_line_step_R3: assert property (@(posedge clk) disable iff (rst)
        (line_latch_i && !wrap_w) |=> (line_q == $past(line_q) + ONE)
                                      && (scan_q == $past(scan_q) + ONE) && $stable(m_q));

    // R3: no latch, no movement
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !line_latch_i |=> $stable(line_q) && $stable(scan_q) && $stable(m_q));

    // R1: a write alone never moves the row address
    assert_start_deferred_R1: assert property (@(posedge clk) disable iff (rst)
        (start_wr_i && !line_latch_i) |=> $stable(line_q));

endmodule

// File: rtl/lcd_seg_encoder.sv
module lcd_seg_encoder
    import lcd_scan_pkg::*;
#(
    parameter int COLS   = 132,
    localparam int OUT_W = COLS * LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COLS-1:0]  row_i,
    input  logic             m_i,
    input  disp_mode_t       mode_i,
    output logic [OUT_W-1:0] seg_o
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic     lit;
        drv_lvl_e nxt;
        drv_lvl_e lvl_q;

        always_comb begin
            lit = mode_i.disp_on & ((row_i[c] | mode_i.all_on) ^ mode_i.reverse);
            nxt = mode_i.pwr_save ? LVL_VSS : seg_level(lit, m_i);
        end

        always_ff @(posedge clk) begin
            if (rst) lvl_q <= LVL_VSS;
            else     lvl_q <= nxt;
        end

        assign seg_o[c*LVL_W +: LVL_W] = lvl_q;

        // R9: a blanked column can only sit at one of the unlit levels
        assert_blank_unlit_R9: assert property (@(posedge clk) disable iff (rst)
            (!mode_i.pwr_save && !mode_i.disp_on) |=> (lvl_q == LVL_V2 || lvl_q == LVL_V3));
    end

    // R11: power save grounds every column on the next edge
    assert_seg_pwr_save_R11: assert property (@(posedge clk) disable iff (rst)
        mode_i.pwr_save |=> (seg_o == '0));

endmodule

// File: rtl/lcd_com_encoder.sv
module lcd_com_encoder
    import lcd_scan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     m_i,
    input  logic     pwr_save_i,
    output drv_lvl_e on_lvl_o,
    output drv_lvl_e off_lvl_o
);
    drv_lvl_e on_q;
    drv_lvl_e off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= LVL_VSS;
            off_q <= LVL_VSS;
        end else begin
            on_q  <= pwr_save_i ? LVL_VSS : com_level(1'b1, m_i);
            off_q <= pwr_save_i ? LVL_VSS : com_level(1'b0, m_i);
        end
    end

    assign on_lvl_o  = on_q;
    assign off_lvl_o = off_q;

    // R10: outside power save the two common levels always differ
    assert_com_distinct_R10: assert property (@(posedge clk) disable iff (rst)
        !pwr_save_i |=> (on_q != off_q));

    // R11: power save grounds both common codes
    assert_com_pwr_save_R11: assert property (@(posedge clk) disable iff (rst)
        pwr_save_i |=> (on_q == LVL_VSS) && (off_q == LVL_VSS));

endmodule

// File: rtl/lcd_scan_encoder.sv
module lcd_scan_encoder
    import lcd_scan_pkg::*;
#(
    parameter int ROWS     = 128,
    parameter int COLS     = 132,
    parameter int MIN_DUTY = 16,
    localparam int LINE_W  = $clog2(ROWS),
    localparam int SEG_W   = COLS * LVL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr_i,
    input  logic [LINE_W-1:0] start_line_i,
    input  logic [LINE_W-1:0] duty_m1_i,
    input  logic              line_latch_i,
    output logic [LINE_W-1:0] row_addr_o,
    input  logic [COLS-1:0]   row_data_i,
    input  logic              disp_on_i,
    input  logic              reverse_i,
    input  logic              all_on_i,
    input  logic              pwr_save_i,
    output logic              m_o,
    output logic [LINE_W-1:0] com_idx_o,
    output logic [LVL_W-1:0]  com_on_lvl_o,
    output logic [LVL_W-1:0]  com_off_lvl_o,
    output logic [SEG_W-1:0]  seg_lvl_o
);
    disp_mode_t mode;
    logic       m_w;
    drv_lvl_e   com_on_w;
    drv_lvl_e   com_off_w;

    assign mode = '{disp_on: disp_on_i, reverse: reverse_i,
                    all_on: all_on_i, pwr_save: pwr_save_i};

    lcd_line_sequencer #(.ROWS(ROWS), .MIN_DUTY(MIN_DUTY)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_wr_i   (start_wr_i),
        .start_line_i (start_line_i),
        .duty_m1_i    (duty_m1_i),
        .line_latch_i (line_latch_i),
        .row_addr_o   (row_addr_o),
        .scan_idx_o   (com_idx_o),
        .m_o          (m_w)
    );

    lcd_seg_encoder #(.COLS(COLS)) u_seg (
        .clk    (clk),
        .rst    (rst),
        .row_i  (row_data_i),
        .m_i    (m_w),
        .mode_i (mode),
        .seg_o  (seg_lvl_o)
    );

    lcd_com_encoder u_com (
        .clk        (clk),
        .rst        (rst),
        .m_i        (m_w),
        .pwr_save_i (pwr_save_i),
        .on_lvl_o   (com_on_w),
        .off_lvl_o  (com_off_w)
    );

    assign m_o           = m_w;
    assign com_on_lvl_o  = com_on_w;
    assign com_off_lvl_o = com_off_w;

endmodule

// File: tb/lcd_scan_encoder_tb.sv
module lcd_scan_encoder_tb;
    localparam int COLS = 132;
    localparam int LW   = 7;
    localparam int SW   = COLS * 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_wr = 1'b0;
    logic [LW-1:0] start_line = '0;
    logic [LW-1:0] duty_m1 = 7'd15;
    logic          line_latch = 1'b0;
    logic [LW-1:0] row_addr;
    logic [COLS-1:0] row_data = '0;
    logic          disp_on = 1'b1, reverse = 1'b0, all_on = 1'b0, pwr_save = 1'b0;
    logic          m_o;
    logic [LW-1:0] com_idx;
    logic [2:0]    com_on, com_off;
    logic [SW-1:0] seg_lvl;

    always #5 clk = ~clk;

    lcd_scan_encoder u_dut (
        .clk(clk), .rst(rst), .start_wr_i(start_wr), .start_line_i(start_line),
        .duty_m1_i(duty_m1), .line_latch_i(line_latch), .row_addr_o(row_addr),
        .row_data_i(row_data), .disp_on_i(disp_on), .reverse_i(reverse),
        .all_on_i(all_on), .pwr_save_i(pwr_save), .m_o(m_o), .com_idx_o(com_idx),
        .com_on_lvl_o(com_on), .com_off_lvl_o(com_off), .seg_lvl_o(seg_lvl)
    );

    // kinds: 0 row, 1 M, 2 com index, 3 segments, 4 com on, 5 com off, 6 carried value
    typedef struct {
        string         req;
        int            kind;
        logic [SW-1:0] exp;
        logic [SW-1:0] act;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    int    line_m = 0, scan_m = 0, start_m = 0;
    logic  m_m = 1'b0;

    task automatic push(string req, int kind, logic [SW-1:0] exp, logic [SW-1:0] act = '0);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp; it.act = act;
        q.push_back(it);
    endtask

    // Monitor: compares queued expectations against the ports, mid low phase
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [SW-1:0] a;
                it = q.pop_front();
                case (it.kind)
                    0: a = SW'(row_addr);
                    1: a = SW'(m_o);
                    2: a = SW'(com_idx);
                    3: a = seg_lvl;
                    4: a = SW'(com_on);
                    5: a = SW'(com_off);
                    default: a = it.act;
                endcase
                checks++;
                if (a !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, a, it.exp);
                end
            end
        end
    end

    function automatic logic [SW-1:0] exp_seg(logic [COLS-1:0] d, logic m);
        logic [SW-1:0] v;
        v = '0;
        for (int c = 0; c < COLS; c++) begin
            logic lit;
            logic [2:0] code;
            lit = disp_on ? ((d[c] | all_on) ^ reverse) : 1'b0;
            if (pwr_save) code = 3'd0;
            else if (lit) code = m ? 3'd1 : 3'd0;
            else          code = m ? 3'd3 : 3'd4;
            v[c*3 +: 3] = code;
        end
        return v;
    endfunction

    task automatic latch();
        int last;
        @(negedge clk);
        line_latch = 1'b1;
        last = (duty_m1 < 15) ? 15 : int'(duty_m1);
        if (scan_m >= last) begin
            scan_m = 0; line_m = start_m; m_m = ~m_m;
        end else begin
            scan_m++; line_m = (line_m + 1) % 128;
        end
        @(negedge clk);
        line_latch = 1'b0;
    endtask

    task automatic push_seq(string req);
        push(req, 0, SW'(line_m));
        push(req, 1, SW'(m_m));
        push(req, 2, SW'(scan_m));
    endtask

    task automatic write_start(int v);
        @(negedge clk);
        start_wr = 1'b1; start_line = LW'(v);
        @(negedge clk);
        start_wr = 1'b0;
        start_m = v;
    endtask

    // Wait one edge so the registered levels see the current inputs, then check
    task automatic check_levels(string seg_req, string com_req);
        @(negedge clk);
        push(seg_req, 3, exp_seg(row_data, m_m));
        push(com_req, 4, SW'(pwr_save ? 3'd0 : (m_m ? 3'd0 : 3'd1)));
        push(com_req, 5, SW'(pwr_save ? 3'd0 : (m_m ? 3'd2 : 3'd5)));
    endtask

    task automatic frame_len(string req);
        logic m0;
        int   n;
        m0 = m_o;
        n = 0;
        while (m_o == m0 && n < 300) begin latch(); n++; end
        m0 = m_o;
        n = 0;
        do begin latch(); n++; end while (m_o == m0 && n < 300);
        push(req, 6, SW'(((duty_m1 < 15) ? 15 : int'(duty_m1)) + 1), SW'(n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired before the run completed");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < COLS; c++) row_data[c] = (c % 3 == 0);
        repeat (3) @(negedge clk);
        // R12: reset state, with data and enables present at the inputs
        push_seq("R12");
        push("R12", 3, '0);
        push("R12", 4, '0);
        push("R12", 5, '0);
        @(negedge clk);
        rst = 1'b0;

        // R3: stepping through the first frame
        for (int i = 1; i <= 15; i++) begin
            latch();
            push_seq("R3");
        end
        repeat (2) @(negedge clk);
        push_seq("R3");                       // held without latches
        // R2: the 16th latch closes the frame
        latch();
        push_seq("R2");

        // R1: deferred start-line load
        write_start(120);
        push("R1", 0, SW'(0));
        for (int i = 0; i < 16; i++) latch();
        push("R1", 0, SW'(120));
        push_seq("R2");
        // R3: wrap of the row address past 127
        for (int i = 0; i < 7; i++) latch();
        push("R3", 0, SW'(127));
        latch();
        push("R3", 0, SW'(0));
        push_seq("R3");

        // R4: clamped short duty and a long duty
        duty_m1 = 7'd3;
        frame_len("R4");
        duty_m1 = 7'd31;
        frame_len("R4");
        duty_m1 = 7'd127;
        frame_len("R4");
        duty_m1 = 7'd15;
        frame_len("R4");

        // R5 R6 R10: normal encoding under both M phases
        check_levels("R6", "R10");
        latch(); while (scan_m != 0) latch();
        check_levels("R6", "R10");
        for (int c = 0; c < COLS; c++) row_data[c] = ((c * 7) % 5 < 2);
        check_levels("R5", "R10");
        // R7: reverse
        reverse = 1'b1;
        check_levels("R7", "R10");
        for (int i = 0; i < 16; i++) latch();
        check_levels("R7", "R10");
        // R8: all on, with and without reverse
        all_on = 1'b1;
        check_levels("R8", "R10");
        reverse = 1'b0;
        check_levels("R8", "R10");
        // R9: display off overrides reverse and all-on
        disp_on = 1'b0; reverse = 1'b1;
        check_levels("R9", "R10");
        for (int i = 0; i < 16; i++) latch();
        check_levels("R9", "R10");
        // R11: power save overrides everything
        pwr_save = 1'b1;
        check_levels("R11", "R11");
        disp_on = 1'b1; all_on = 1'b0; reverse = 1'b0;
        check_levels("R11", "R11");
        pwr_save = 1'b0;
        check_levels("R6", "R10");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule